// File: doc/BRIEF.md
# T1 Zero-Run Alarm Monitor

This block watches the recovered data of a T1 line, one bit for each bit-clock enable, on two rail inputs. A bit is a one when either rail is high and a zero when both rails are low. From this bit stream the block derives four live alarm levels: an eight-zero run, a sixteen-zero run, loss of receive carrier, and the unframed all-ones (blue) alarm. Each level is meant to feed a separate latched status bit elsewhere in the chip.

The two short-run alarms follow the current run of zeros and drop on the next one. Carrier loss is declared after a long run of zeros. It is withdrawn only when enough ones arrive inside a fixed-length span. Those spans run back to back and the first one opens on the first one received after the loss. The blue alarm is judged once per observation window of 4632 bits, which is 3 ms at 1.544 Mb/s. A window with few zeros raises the alarm, and a window with more zeros drops it.

Top module: `t1_zero_alarm_mon`

## Requirements
- R1: A bit is taken only in a cycle with `bit_en` high. It is a one if `rail_pos` or `rail_neg` is high, and a zero if both are low.
- R2: `zero8_alarm` is high from the cycle after the 8th consecutive zero is taken.
- R3: `zero16_alarm` is high from the cycle after the 16th consecutive zero is taken. Whenever it is high, `zero8_alarm` is also high.
- R4: Both `zero8_alarm` and `zero16_alarm` go low in the cycle after a one is taken.
- R5: `carrier_loss_alarm` goes high in the cycle after the 192nd consecutive zero is taken.
- R6: Once carrier loss is declared, the first one taken opens a 112-bit span. Further spans follow back to back with no gap. The alarm goes low in the cycle after the 14th one of a single span is taken. At the end of a span, its ones count is discarded.
- R7: Blue-alarm windows are 4632 taken bits each, back to back, and the first window starts at the first bit after reset. If a window held 5 or fewer zeros, `blue_alarm` is high from the cycle after its last bit.
- R8: If a window held 6 or more zeros, `blue_alarm` is low from the cycle after its last bit. `blue_alarm` changes only in the cycle after the last bit of a window.
- R9: While `bit_en` is low, the rails are ignored and no alarm output changes.
- R10: While the synchronous active-high `rst` is high, all four alarms are low at the next clock edge. Every run, span and window count restarts.
- R11: The zero-run count saturates, so an all-zero input of any length keeps `zero8_alarm`, `zero16_alarm` and `carrier_loss_alarm` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Qualifies one received bit in this cycle |
| rail_pos | input | 1 | Positive rail of the received bit |
| rail_neg | input | 1 | Negative rail of the received bit |
| zero8_alarm | output | 1 | Eight-zero run level |
| zero16_alarm | output | 1 | Sixteen-zero run level |
| carrier_loss_alarm | output | 1 | Receive carrier loss level |
| blue_alarm | output | 1 | Unframed all-ones level |

## Verification
Runs of 7, 8, 15 and 16 zeros tell the exact trip points of the short-run alarms from off-by-one thresholds. Ones sent on only the negative rail show that either rail counts. A run of several hundred zeros separates a saturating run count from one that wraps. For carrier-loss recovery, a one every ninth bit gives 13 ones per span, and a one every eighth bit gives 14 ones. The alarm must hold through the first pattern and clear on the second, which pins down the threshold and the span alignment. For the blue alarm, windows of all ones with exactly 5 and exactly 6 zeros sit on either side of the set and clear limits. Random stretches with gaps in `bit_en` and sparse or dense zeros check that idle cycles are ignored and that status changes only at window edges.

// File: rtl/t1za_pkg.sv
package t1za_pkg;

   // One qualified line bit: valid marks a taken bit, one is its decoded value
   typedef struct packed {
      logic valid;
      logic one;
   } line_bit_t;

endpackage

// File: rtl/t1za_run_tracker.sv
module t1za_run_tracker
   import t1za_pkg::*;
#(
   parameter int SHORT_RUN = 8,
   parameter int LONG_RUN  = 16,
   parameter int LOSS_RUN  = 192,
   parameter int RUN_W     = $clog2(LOSS_RUN + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  line_bit_t        lb,
   output logic [RUN_W-1:0] run_cnt,
   output logic             z_short,
   output logic             z_long
);

   localparam int NLIM = 2;
   localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(LOSS_RUN);

   logic [NLIM-1:0] run_flags;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_cnt <= '0;
      end else if (lb.valid) begin
         if (lb.one)
            run_cnt <= '0;
         else if (run_cnt != RUN_SAT)
            run_cnt <= run_cnt + 1'b1;
      end
   end

   // One comparator per run threshold
   generate
      for (genvar i = 0; i < NLIM; i++) begin : g_lim
         localparam int LIM = (i == 0) ? SHORT_RUN : LONG_RUN;
         assign run_flags[i] = (run_cnt >= RUN_W'(LIM));
      end
   endgenerate

   assign z_short = run_flags[0];
   assign z_long  = run_flags[1];

   p_sat_r11: assert property (@(posedge clk) disable iff (rst)
      run_cnt <= RUN_SAT);
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !lb.valid |=> $stable(run_cnt));
   p_nest_r3: assert property (@(posedge clk) disable iff (rst)
      z_long |-> z_short);
   p_one_clears_r4: assert property (@(posedge clk) disable iff (rst)
      (lb.valid && lb.one) |=> (!z_short && !z_long));

endmodule

// File: rtl/t1za_carrier_loss.sv
module t1za_carrier_loss
   import t1za_pkg::*;
#(
   parameter int LOSS_RUN   = 192,
   parameter int RECOV_SPAN = 112,
   parameter int RECOV_ONES = 14,
   parameter int RUN_W      = $clog2(LOSS_RUN + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  line_bit_t        lb,
   input  logic [RUN_W-1:0] run_cnt,
   output logic             loss
);

   localparam int SPAN_W = $clog2(RECOV_SPAN + 1);
   localparam int ONES_W = $clog2(RECOV_ONES + 1);
   localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(LOSS_RUN - 1);
   localparam logic [SPAN_W-1:0] SPAN_LAST = SPAN_W'(RECOV_SPAN - 1);
   localparam logic [ONES_W-1:0] ONES_LAST = ONES_W'(RECOV_ONES - 1);

   logic              win_on;
   logic [SPAN_W-1:0] span_cnt;
   logic [ONES_W-1:0] ones_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         loss     <= 1'b0;
         win_on   <= 1'b0;
         span_cnt <= '0;
         ones_cnt <= '0;
      end else if (lb.valid) begin
         if (!loss) begin
            if (!lb.one && run_cnt == RUN_LAST)
               loss <= 1'b1;
            win_on   <= 1'b0;
            span_cnt <= '0;
            ones_cnt <= '0;
         end else if (!win_on) begin
            // first one after the loss opens the first span
            if (lb.one) begin
               win_on   <= 1'b1;
               span_cnt <= SPAN_W'(1);
               ones_cnt <= ONES_W'(1);
            end
         end else if (lb.one && ones_cnt == ONES_LAST) begin
            loss   <= 1'b0;
            win_on <= 1'b0;
         end else if (span_cnt == SPAN_LAST) begin
            span_cnt <= '0;
            ones_cnt <= '0;
         end else begin
            span_cnt <= span_cnt + 1'b1;
            ones_cnt <= ones_cnt + ONES_W'(lb.one);
         end
      end
   end

   p_loss_set_r5: assert property (@(posedge clk) disable iff (rst)
      (lb.valid && !lb.one && run_cnt == RUN_LAST) |=> loss);
   p_loss_clear_r6: assert property (@(posedge clk) disable iff (rst)
      $fell(loss) |-> ($past(ones_cnt) == ONES_LAST && $past(lb.one) && $past(win_on)));
   p_span_bound_r6: assert property (@(posedge clk) disable iff (rst)
      span_cnt < SPAN_W'(RECOV_SPAN));

endmodule

// File: rtl/t1za_blue_window.sv
module t1za_blue_window
   import t1za_pkg::*;
#(
   parameter int BLUE_WIN       = 4632,
   parameter int BLUE_MAX_ZEROS = 5
) (
   input  logic      clk,
   input  logic      rst,
   input  line_bit_t lb,
   output logic      blue
);

   localparam int POS_W = $clog2(BLUE_WIN);
   localparam int ZC_W  = $clog2(BLUE_MAX_ZEROS + 2);
   localparam logic [POS_W-1:0] POS_LAST = POS_W'(BLUE_WIN - 1);
   localparam logic [ZC_W-1:0]  ZC_SAT   = ZC_W'(BLUE_MAX_ZEROS + 1);
   localparam logic [ZC_W-1:0]  ZC_MAX   = ZC_W'(BLUE_MAX_ZEROS);

   logic [POS_W-1:0] pos;
   logic [ZC_W-1:0]  zc;
   logic [ZC_W-1:0]  zc_next;
   logic             at_end;

   always_comb begin
      zc_next = zc;
      if (!lb.one && zc != ZC_SAT)
         zc_next = zc + 1'b1;
   end

   assign at_end = (pos == POS_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         pos  <= '0;
         zc   <= '0;
         blue <= 1'b0;
      end else if (lb.valid) begin
         if (at_end) begin
            blue <= (zc_next <= ZC_MAX);
            pos  <= '0;
            zc   <= '0;
         end else begin
            pos <= pos + 1'b1;
            zc  <= zc_next;
         end
      end
   end

   p_blue_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !(lb.valid && at_end) |=> $stable(blue));
   p_zc_bound_r7: assert property (@(posedge clk) disable iff (rst)
      zc <= ZC_SAT);

endmodule

// File: rtl/t1_zero_alarm_mon.sv
module t1_zero_alarm_mon
   import t1za_pkg::*;
#(
   parameter int SHORT_RUN      = 8,
   parameter int LONG_RUN       = 16,
   parameter int LOSS_RUN       = 192,
   parameter int RECOV_SPAN     = 112,
   parameter int RECOV_ONES     = 14,
   parameter int BLUE_WIN       = 4632,
   parameter int BLUE_MAX_ZEROS = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic rail_pos,
   input  logic rail_neg,
   output logic zero8_alarm,
   output logic zero16_alarm,
   output logic carrier_loss_alarm,
   output logic blue_alarm
);

   localparam int RUN_W = $clog2(LOSS_RUN + 1);

   initial begin
      a_short_lt_long: assert (SHORT_RUN >= 1 && SHORT_RUN < LONG_RUN)
         else $error("short run limit must be positive and below long run limit");
      a_long_le_loss: assert (LONG_RUN <= LOSS_RUN)
         else $error("long run limit must not exceed carrier loss run");
      a_ones_fit_span: assert (RECOV_ONES >= 2 && RECOV_ONES <= RECOV_SPAN)
         else $error("recovery ones count must lie in 2..span");
      a_blue_win: assert (BLUE_WIN > BLUE_MAX_ZEROS + 1)
         else $error("blue window must exceed its zero limit");
   end

   line_bit_t        lb;
   logic [RUN_W-1:0] run_cnt;

   assign lb.valid = bit_en;
   assign lb.one   = rail_pos | rail_neg;

   t1za_run_tracker #(
      .SHORT_RUN (SHORT_RUN),
      .LONG_RUN  (LONG_RUN),
      .LOSS_RUN  (LOSS_RUN),
      .RUN_W     (RUN_W)
   ) u_run (
      .clk     (clk),
      .rst     (rst),
      .lb      (lb),
      .run_cnt (run_cnt),
      .z_short (zero8_alarm),
      .z_long  (zero16_alarm)
   );

   t1za_carrier_loss #(
      .LOSS_RUN   (LOSS_RUN),
      .RECOV_SPAN (RECOV_SPAN),
      .RECOV_ONES (RECOV_ONES),
      .RUN_W      (RUN_W)
   ) u_loss (
      .clk     (clk),
      .rst     (rst),
      .lb      (lb),
      .run_cnt (run_cnt),
      .loss    (carrier_loss_alarm)
   );

   t1za_blue_window #(
      .BLUE_WIN       (BLUE_WIN),
      .BLUE_MAX_ZEROS (BLUE_MAX_ZEROS)
   ) u_blue (
      .clk  (clk),
      .rst  (rst),
      .lb   (lb),
      .blue (blue_alarm)
   );

   p_rail_one_r1: assert property (@(posedge clk) disable iff (rst)
      (bit_en && (rail_pos || rail_neg)) |=> !zero8_alarm);
   p_reset_clear_r10: assert property (@(posedge clk)
      rst |=> (!zero8_alarm && !zero16_alarm && !carrier_loss_alarm && !blue_alarm));

endmodule

// File: tb/t1_zero_alarm_mon_test.sv
`timescale 1ns/1ps
module t1_zero_alarm_mon_test;

   localparam int WIN = 4632;
   localparam int WATCHDOG_CYCLES = 150000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_en = 1'b0;
   logic rail_pos = 1'b0;
   logic rail_neg = 1'b0;
   logic zero8_alarm, zero16_alarm, carrier_loss_alarm, blue_alarm;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // reference state, built from the requirements
   int  m_run;
   bit  m_loss, m_won;
   int  m_span, m_ones;
   int  m_pos, m_zc;
   bit  m_blue;

   always #10 clk = ~clk;

   t1_zero_alarm_mon uut (
      .clk(clk), .rst(rst), .bit_en(bit_en),
      .rail_pos(rail_pos), .rail_neg(rail_neg),
      .zero8_alarm(zero8_alarm), .zero16_alarm(zero16_alarm),
      .carrier_loss_alarm(carrier_loss_alarm), .blue_alarm(blue_alarm)
   );

   function automatic bit exp_z8();
      return m_run >= 8;
   endfunction

   function automatic bit exp_z16();
      return m_run >= 16;
   endfunction

   task automatic check(string req, string what, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_all(string req);
      check({req, " R2 R4"}, "zero8", zero8_alarm, exp_z8());
      check({req, " R3 R4"}, "zero16", zero16_alarm, exp_z16());
      check({req, " R5 R6"}, "carrier_loss", carrier_loss_alarm, m_loss);
      check({req, " R7 R8"}, "blue", blue_alarm, m_blue);
   endtask

   task automatic model_reset();
      m_run = 0; m_loss = 0; m_won = 0; m_span = 0; m_ones = 0;
      m_pos = 0; m_zc = 0; m_blue = 0;
   endtask

   task automatic model_bit(bit one);
      // carrier loss uses the run length before this bit (R5, R6)
      if (!m_loss) begin
         if (!one && m_run == 191) m_loss = 1;
         m_won = 0;
      end else if (!m_won) begin
         if (one) begin m_won = 1; m_span = 1; m_ones = 1; end
      end else begin
         m_span++;
         if (one) m_ones++;
         if (m_ones >= 14) begin m_loss = 0; m_won = 0; end
         else if (m_span == 112) begin m_span = 0; m_ones = 0; end
      end
      // zero run, saturating (R11)
      if (one) m_run = 0;
      else if (m_run < 192) m_run++;
      // blue window (R7, R8)
      if (!one) m_zc++;
      m_pos++;
      if (m_pos == WIN) begin
         m_blue = (m_zc <= 5);
         m_pos = 0;
         m_zc = 0;
      end
   endtask

   // One taken bit: drive at a falling edge, compare at the next falling edge
   task automatic send(bit p, bit n, string req);
      bit_en = 1'b1; rail_pos = p; rail_neg = n;
      model_bit(p | n);
      @(negedge clk);
      check_all(req);
   endtask

   task automatic send_one(string req);
      send(1'b1, 1'b0, req);
   endtask

   task automatic send_zero(string req);
      send(1'b0, 1'b0, req);
   endtask

   // idle cycle: random rails, no enable (R9)
   task automatic idle();
      bit_en = 1'b0; rail_pos = 1'($urandom); rail_neg = 1'($urandom);
      @(negedge clk);
      check_all("R9");
   endtask

   task automatic do_reset();
      rst = 1'b1; bit_en = 1'b0;
      repeat (2) @(negedge clk);
      model_reset();
      check_all("R10");
      rst = 1'b0;
   endtask

   // Window of all ones with a given number of zeros at random spots
   task automatic blue_window_with(int zeros, string req);
      int left = zeros;
      for (int i = 0; i < WIN; i++) begin
         bit z;
         z = (left > 0) && ((WIN - i) == left || ($urandom % 600) == 0);
         if (z) begin left--; send_zero(req); end
         else send(1'b0, 1'b1, req);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      @(negedge clk);
      do_reset();

      // short runs: 7 then 8 zeros, ones on the negative rail only (R1, R2, R4)
      send(1'b0, 1'b1, "R1");
      for (int i = 0; i < 7; i++) send_zero("R2");
      send(1'b0, 1'b1, "R1 R4");
      for (int i = 0; i < 8; i++) send_zero("R2");
      send(1'b1, 1'b1, "R4");
      // 15 then 16 zeros (R3)
      for (int i = 0; i < 15; i++) send_zero("R3");
      send_one("R4");
      for (int i = 0; i < 16; i++) send_zero("R3");
      idle(); idle();
      send_one("R4");

      // long zero run beyond the saturation point (R5, R11)
      for (int i = 0; i < 191; i++) send_zero("R5");
      send_zero("R5");
      for (int i = 0; i < 150; i++) begin
         if (i % 17 == 0) idle();
         send_zero("R11");
      end

      // 13 ones per span: loss must hold across two spans (R6)
      for (int i = 0; i < 224; i++) begin
         if (i % 9 == 0) send_one("R6"); else send_zero("R6");
      end
      // 14 ones in one span: loss clears on the 14th (R6)
      for (int i = 0; i < 112; i++) begin
         if (i % 8 == 0) send_one("R6"); else send_zero("R6");
      end

      // align blue windows with a reset in the middle of activity (R10)
      do_reset();
      blue_window_with(5, "R7");
      blue_window_with(6, "R8");
      blue_window_with(0, "R7");
      blue_window_with(5, "R7");

      // random traffic with gaps in the enable: sparse then dense zeros
      for (int i = 0; i < 6000; i++) begin
         if (($urandom % 5) == 0) idle();
         else if (($urandom % 1500) == 0) send_zero("R8");
         else send(1'($urandom), 1'b1, "R7");
      end
      for (int i = 0; i < 6000; i++) begin
         if (($urandom % 5) == 0) idle();
         else send(1'($urandom % 3 == 0), 1'($urandom % 3 == 0), "R1");
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule